// File: doc/BRIEF.md
# Serial Clock-Synthesizer Program Loader

This block loads a new frequency setting into one of two external clock-synthesizer chips over their serial programming pins. The two chips share one data line. Each chip has its own shift clock and latches the data line on the rising edge of that clock. A host supplies a 22-bit program word and a target index, then pulses a start strobe. The block then shifts out a fixed seven-frame sequence without further host involvement:

1. A control word that parks the target on its reference clock.
2. A flag word.
3. The program word, with zero-stuffing applied.
4. A control word that makes the target accept the new word.
5. A flag word.
6. A control word that switches the target to its synthesized output.
7. A closing flag word.

Shift-clock timing comes from a parameterized divider of the system clock, so the pins can stay slow compared with the chips' own reference, which runs at about 16.7 MHz. The host watches `busy_o` while a load is under way and sees a one-cycle `done_o` pulse when the load ends. The control and flag bit patterns are parameters.

Top module: `synth_prog_loader`

## Requirements
- R1: While reset is held and after it is released, the outputs are idle: every shift clock is 0, `sdata_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: One load sends exactly seven frames, one after another:
  - an 8-bit `CW_TO_REF` (default 8'h1E);
  - a 6-bit `FLAG_WORD` (default 6'h1E);
  - the 22-bit program word plus its stuffed zeros;
  - an 8-bit `CW_ACCEPT` (default 8'h5A);
  - `FLAG_WORD`;
  - an 8-bit `CW_TO_SYN` (default 8'h0F);
  - `FLAG_WORD`.
- R3: Every frame is sent least significant bit first.
- R4: Inside the program-word frame, each run of three consecutive payload 1 bits is followed by one inserted 0 bit. This also applies when the run ends on the last payload bit. The inserted bit does not count toward the 22 payload bits, and the run count restarts after it.
- R5: Only the selected target's shift clock pulses during a load: `target_i` = 0 selects `sclk_o[0]` and 1 selects `sclk_o[1]`. The other shift clock stays 0 for the whole load.
- R6: Each bit takes 2×`CLK_DIV` system cycles. The shift clock is low for the first `CLK_DIV` cycles of the bit and high for the rest, and `sdata_o` does not change while the shift clock is high or on the cycle it rises.
- R7: `busy_o` rises on the cycle after an accepted start and stays high for exactly (total bits)×2×`CLK_DIV` cycles. A start pulse while busy is ignored: it changes neither the bit stream nor the target.
- R8: `done_o` is high for exactly one cycle, on the cycle the final flag bit's high phase ends. From that cycle on, both shift clocks are 0 and `sdata_o` is 0 until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a load |
| target_i | input | TSEL_W | Index of the synthesizer to program |
| prog_word_i | input | PROG_W | Program word, sampled on an accepted start |
| busy_o | output | 1 | High while a load is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a load |
| sclk_o | output | NUM_TARGETS | Per-target shift clocks |
| sdata_o | output | 1 | Shared serial data line |

## Verification
The bench records the data line on every rising edge of each shift clock and compares the recorded stream with a stream it builds arithmetically from the requirements. The stimulus sweeps program words that stress the stuffing counter:
- all ones, which must give seven stuffed zeros;
- a run that ends on the last payload bit, which catches a design that drops the trailing stuffed zero or leaves the frame early;
- runs of exactly two ones, where a counter off by one would stuff where it should not.

Busy-cycle counts catch wrong frame lengths or pacing. A start issued in mid-load with a different target and word catches a design that re-arms, which would corrupt the stream or move the clock to the other chip.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
   // Frame order is behaviour: the chips expect exactly this sequence.
   typedef enum logic [2:0] {
      FR_TO_REF  = 3'd0,
      FR_FLAG_A  = 3'd1,
      FR_PROGRAM = 3'd2,
      FR_ACCEPT  = 3'd3,
      FR_FLAG_B  = 3'd4,
      FR_TO_SYN  = 3'd5,
      FR_FLAG_C  = 3'd6
   } frame_e;
endpackage

// File: rtl/synth_pace.sv
module synth_pace #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   if (CLK_DIV < 1) begin : g_bad_div
      $error("synth_pace: CLK_DIV must be at least 1");
   end

   if (CLK_DIV == 1) begin : g_every
      assign tick_o = run_i;
   end else begin : g_count
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || !run_i) cnt_q <= '0;
         else if (cnt_q == LAST) cnt_q <= '0;
         else cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = run_i && (cnt_q == LAST);

      // R6: a phase lasts CLK_DIV cycles, so two ticks never come back to back
      assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end
endmodule

// File: rtl/synth_frame_seq.sv
module synth_frame_seq
   import synth_prog_pkg::*;
#(
   parameter int PROG_W    = 22,
   parameter int CTRL_W    = 8,
   parameter int FLAG_W    = 6,
   parameter int RUN_LIMIT = 3,
   parameter logic [CTRL_W-1:0] CW_TO_REF = 8'h1E,
   parameter logic [CTRL_W-1:0] CW_ACCEPT = 8'h5A,
   parameter logic [CTRL_W-1:0] CW_TO_SYN = 8'h0F,
   parameter logic [FLAG_W-1:0] FLAG_WORD = 6'h1E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [PROG_W-1:0] word_i,
   input  logic              tick_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              phase_o,
   output logic              bit_o
);
   localparam int VEC_W0 = (PROG_W > CTRL_W) ? PROG_W : CTRL_W;
   localparam int VEC_W  = (VEC_W0 > FLAG_W) ? VEC_W0 : FLAG_W;
   localparam int BIT_W  = $clog2(VEC_W + 1);
   localparam int RUN_W  = $clog2(RUN_LIMIT + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LIMIT - 1);
   localparam logic [BIT_W-1:0] PROG_END = BIT_W'(PROG_W);

   if (RUN_LIMIT < 1) begin : g_bad_run
      $error("synth_frame_seq: RUN_LIMIT must be at least 1");
   end
   if (PROG_W < 1 || CTRL_W < 1 || FLAG_W < 1) begin : g_bad_width
      $error("synth_frame_seq: frame widths must be positive");
   end

   frame_e            frame_q;
   logic [BIT_W-1:0]  bit_q;
   logic [RUN_W-1:0]  run_q;
   logic              stuff_q, phase_q, busy_q, done_q;
   logic [PROG_W-1:0] word_q;

   logic [VEC_W-1:0]  vec, vec_sh;
   logic [BIT_W-1:0]  len_m1;

   always_comb begin
      unique case (frame_q)
         FR_TO_REF:  begin vec = VEC_W'(CW_TO_REF); len_m1 = BIT_W'(CTRL_W - 1); end
         FR_PROGRAM: begin vec = VEC_W'(word_q);    len_m1 = BIT_W'(PROG_W - 1); end
         FR_ACCEPT:  begin vec = VEC_W'(CW_ACCEPT); len_m1 = BIT_W'(CTRL_W - 1); end
         FR_TO_SYN:  begin vec = VEC_W'(CW_TO_SYN); len_m1 = BIT_W'(CTRL_W - 1); end
         default:    begin vec = VEC_W'(FLAG_WORD); len_m1 = BIT_W'(FLAG_W - 1); end
      endcase
   end

   assign vec_sh = vec >> bit_q;
   wire payload  = vec_sh[0];
   wire cur_bit  = stuff_q ? 1'b0 : payload;
   wire last_bit = (bit_q == len_m1);
   wire adv      = busy_q && tick_i && phase_q;
   wire in_prog  = (frame_q == FR_PROGRAM);
   wire need_stf = in_prog && !stuff_q && payload && (run_q == RUN_LAST);
   wire frame_end = in_prog ? (stuff_q ? (bit_q == PROG_END) : (last_bit && !need_stf))
                            : last_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= FR_TO_REF;
         bit_q   <= '0;
         run_q   <= '0;
         stuff_q <= 1'b0;
         phase_q <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         word_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q  <= 1'b1;
               word_q  <= word_i;
               frame_q <= FR_TO_REF;
               bit_q   <= '0;
               run_q   <= '0;
               stuff_q <= 1'b0;
               phase_q <= 1'b0;
            end
         end else if (tick_i) begin
            phase_q <= !phase_q;
            if (adv) begin
               if (frame_end) begin
                  bit_q   <= '0;
                  run_q   <= '0;
                  stuff_q <= 1'b0;
                  if (frame_q == FR_FLAG_C) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     frame_q <= frame_e'(frame_q + 3'd1);
                  end
               end else if (stuff_q) begin
                  stuff_q <= 1'b0;
                  run_q   <= '0;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  if (in_prog) begin
                     if (need_stf) begin
                        stuff_q <= 1'b1;
                        run_q   <= '0;
                     end else if (payload) run_q <= run_q + 1'b1;
                     else run_q <= '0;
                  end
               end
            end
         end
      end
   end

   assign busy_o  = busy_q;
   assign done_o  = done_q;
   assign phase_o = phase_q;
   assign bit_o   = cur_bit;

   // R4: the run count never reaches the limit; a stuffed zero intervenes first
   assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < RUN_W'(RUN_LIMIT));
   // R4: stuffed zeros appear only inside the program-word frame
   assert_stuff_in_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_q |-> in_prog);
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader #(
   parameter int NUM_TARGETS = 2,
   parameter int TSEL_W      = (NUM_TARGETS > 1) ? $clog2(NUM_TARGETS) : 1,
   parameter int CLK_DIV     = 4,
   parameter int PROG_W      = 22,
   parameter int CTRL_W      = 8,
   parameter int FLAG_W      = 6,
   parameter int RUN_LIMIT   = 3,
   parameter logic [CTRL_W-1:0] CW_TO_REF = 8'h1E,
   parameter logic [CTRL_W-1:0] CW_ACCEPT = 8'h5A,
   parameter logic [CTRL_W-1:0] CW_TO_SYN = 8'h0F,
   parameter logic [FLAG_W-1:0] FLAG_WORD = 6'h1E
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [TSEL_W-1:0]      target_i,
   input  logic [PROG_W-1:0]      prog_word_i,
   output logic                   busy_o,
   output logic                   done_o,
   output logic [NUM_TARGETS-1:0] sclk_o,
   output logic                   sdata_o
);
   if (NUM_TARGETS < 1) begin : g_bad_tgt
      $error("synth_prog_loader: NUM_TARGETS must be at least 1");
   end

   logic              tick, busy, done, phase, cur_bit;
   logic [TSEL_W-1:0] tsel_q;

   synth_pace #(.CLK_DIV(CLK_DIV)) u_pace (
      .clk(clk), .rst_n(rst_n), .run_i(busy), .tick_o(tick));

   synth_frame_seq #(
      .PROG_W(PROG_W), .CTRL_W(CTRL_W), .FLAG_W(FLAG_W), .RUN_LIMIT(RUN_LIMIT),
      .CW_TO_REF(CW_TO_REF), .CW_ACCEPT(CW_ACCEPT), .CW_TO_SYN(CW_TO_SYN),
      .FLAG_WORD(FLAG_WORD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(prog_word_i),
      .tick_i(tick), .busy_o(busy), .done_o(done), .phase_o(phase), .bit_o(cur_bit));

   always_ff @(posedge clk) begin
      if (!rst_n) tsel_q <= '0;
      else if (start_i && !busy) tsel_q <= target_i;
   end

   for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_sclk
      assign sclk_o[t] = busy && phase && (tsel_q == TSEL_W'(t));
   end

   assign sdata_o = busy && cur_bit;
   assign busy_o  = busy;
   assign done_o  = done;

   // R1 / R8: nothing toggles on the pins while idle
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (sclk_o == '0) && !sdata_o);
   // R5: at most one shift clock active at a time
   assert_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sclk_o));
   // R7: the chosen target cannot move during a load
   assert_target_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(tsel_q));
   // R6: data stays put across the rising edge and the high phase
   assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|sclk_o) |-> $stable(sdata_o));
   // R8: done is a single-cycle pulse coinciding with the end of busy
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $fell(busy_o)) ##1 !done_o);
endmodule

// File: tb/synth_prog_loader_bench.sv
module synth_prog_loader_bench;
   localparam int DIV = 2;
   localparam logic [7:0] C_REF = 8'h1E, C_ACC = 8'h5A, C_SYN = 8'h0F;
   localparam logic [5:0] FLG = 6'h1E;

   logic clk = 0, rst_n = 0, start = 0;
   logic [0:0]  tgt = 0;
   logic [21:0] word = 0;
   logic busy, done, sdata;
   logic [1:0] sclk;

   always #2.5 clk = ~clk;

   synth_prog_loader #(.CLK_DIV(DIV)) u_synth_prog_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(tgt),
      .prog_word_i(word), .busy_o(busy), .done_o(done), .sclk_o(sclk), .sdata_o(sdata));

   int checks = 0, fails = 0, cycles = 0;
   bit exp_bits [0:127];
   int exp_n;
   bit cap [0:127];
   int cap_n, other_rise, busy_cnt, done_cnt, done_bad;
   int sel;
   logic [1:0] prev_sclk = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic push(input logic [31:0] v, input int n);
      for (int i = 0; i < n; i++) begin exp_bits[exp_n] = v[i]; exp_n++; end
   endtask

   task automatic build(input logic [21:0] w);
      int run;
      exp_n = 0;
      push(32'(C_REF), 8); push(32'(FLG), 6);
      run = 0;
      for (int i = 0; i < 22; i++) begin
         exp_bits[exp_n] = w[i]; exp_n++;
         if (w[i]) run++; else run = 0;
         if (run == 3) begin exp_bits[exp_n] = 0; exp_n++; run = 0; end
      end
      push(32'(C_ACC), 8); push(32'(FLG), 6);
      push(32'(C_SYN), 8); push(32'(FLG), 6);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk[sel] && !prev_sclk[sel] && cap_n < 128) begin cap[cap_n] = sdata; cap_n++; end
         if (sclk[1-sel] && !prev_sclk[1-sel]) other_rise++;
         if (busy) busy_cnt++;
         if (done) begin
            done_cnt++;
            if (busy || sclk != 0 || sdata) done_bad++;
         end
      end
      prev_sclk = sclk;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic run_load(input logic [21:0] w, input int t, input bit poke);
      int mism;
      build(w);
      sel = t; cap_n = 0; other_rise = 0; busy_cnt = 0; done_cnt = 0; done_bad = 0;
      @(negedge clk); word = w; tgt = 1'(t); start = 1;
      @(negedge clk); start = 0;
      if (poke) begin
         repeat (40) @(negedge clk);
         word = ~w; tgt = 1'(1 - t); start = 1;
         @(negedge clk); start = 0;
      end
      while (done_cnt == 0) @(negedge clk);
      repeat (6) @(negedge clk);
      mism = 0;
      for (int i = 0; i < exp_n; i++) if (cap[i] != exp_bits[i]) mism++;
      chk(cap_n == exp_n, "R2 R4 bit count", cap_n, exp_n);
      chk(mism == 0, "R3 R4 stream match (mismatched bits)", mism, 0);
      chk(other_rise == 0, "R5 unselected clock edges", other_rise, 0);
      chk(busy_cnt == exp_n * 2 * DIV, "R6 R7 busy cycles", busy_cnt, exp_n * 2 * DIV);
      chk(done_cnt == 1 && done_bad == 0, "R8 done pulse count", done_cnt, 1);
      chk(!busy && sclk == 0 && !sdata, "R8 idle after done", int'(sclk), 0);
   endtask

   initial begin
      logic [21:0] lf;
      repeat (3) @(negedge clk);
      chk(sclk == 0 && !sdata && !busy && !done, "R1 outputs in reset", int'(sclk), 0);
      rst_n = 1;
      @(negedge clk);
      chk(sclk == 0 && !sdata && !busy && !done, "R1 outputs after reset", int'(busy), 0);
      run_load(22'h000000, 0, 0);
      run_load(22'h3FFFFF, 1, 0);   // R4: seven stuffed zeros
      run_load(22'h2AAAAA, 0, 0);
      run_load(22'h1B6DB6, 1, 0);   // R4: runs of two only
      run_load(22'h380000, 0, 0);   // R4: run ends on last payload bit
      run_load(22'h000007, 1, 0);
      run_load(22'h0F0F0F, 0, 1);   // R7: start while busy is ignored
      lf = 22'h12345;
      for (int k = 0; k < 4; k++) begin
         lf = {lf[20:0], lf[21] ^ lf[20]};
         lf = lf ^ 22'(k * 22'h0B5A3);
         run_load(lf, k % 2, 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule